// File: doc/BRIEF.md
# Bank-Gated Direct-Mapped Cache Array

This block is the storage array of a direct-mapped cache, split into four equal banks. Each bank is 64 bits wide and holds its own data words, tags and valid bits. The top bits of the cache index choose one bank per access. Only that bank receives an enable, so the other banks keep their storage and output registers still and draw no switching power. The default size is 8 KB with 16-byte lines. Set `CACHE_BYTES` to 16384 for a 16 KB instruction-side array.

A lookup port takes an address, a read or write request, write data and byte enables. One cycle later it returns a hit flag and the read word. A write changes only the enabled bytes, and only on a hit. A miss leaves the array unchanged and never allocates a line. A separate fill port writes a whole line, its tag and its valid bit into the line chosen by the fill address. The per-bank enables are outputs, so the power gating can be observed from outside.

Top module: `cache_bank_array`

## Requirements
- R1: With the default parameters, an address splits as follows: tag = addr[31:13], bank = addr[12:11], row within the bank = addr[10:4], word within the line = addr[3]. addr[2:0] is the byte within the 64-bit word and is ignored.
- R2: While `req` or `fill_en` is high, exactly one bit of `bank_en` is high, and it is the bit indexed by the bank field of the active address. A disabled bank keeps its output registers unchanged.
- R3: While neither `req` nor `fill_en` is high, `bank_en` is all zero.
- R4: `rvalid` is high in the cycle after a request that had no fill beside it, and low otherwise. `hit` is high only when the line is valid and its stored tag equals the address tag.
- R5: A read hit returns the stored 64-bit word on `rdata`. A read miss returns zero, and any write returns zero.
- R6: A fill writes the whole line in one cycle, with word 0 taken from `fill_data[63:0]` and word 1 from `fill_data[127:64]`. It stores the tag and sets the valid bit.
- R7: A write hit replaces only the bytes whose `be` bit is set, with `be[k]` covering data bits [8k+7:8k]. A write miss changes nothing.
- R8: When `fill_en` and `req` are high in the same cycle, the fill takes place, the request is dropped, and no `rvalid` follows.
- R9: After reset every line is invalid, so every lookup misses.
- R10: Addresses that differ only in the bank field select different lines. Filling one of them leaves the others missing, and reads of one line are not disturbed by fills of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Lookup request |
| we | input | 1 | Request is a write |
| addr | input | 32 | Lookup byte address |
| wdata | input | 64 | Write data |
| be | input | 8 | Byte enables for the write |
| fill_en | input | 1 | Line fill strobe |
| fill_addr | input | 32 | Address of the line to fill |
| fill_data | input | 128 | Whole line, word 0 in the low half |
| bank_en | output | 4 | Per-bank enable of the current cycle |
| rvalid | output | 1 | Result of the previous cycle's request |
| hit | output | 1 | Lookup hit |
| rdata | output | 64 | Read word on a read hit, otherwise zero |

## Verification
`bank_en` is combinational from the request and fill inputs, so it is checked in the same cycle, shortly after the inputs settle. `rvalid`, `hit` and `rdata` come from one register stage and are checked at the next falling edge, one cycle after the request is presented. A fill or a write takes effect at the edge that ends its cycle. Its effect is therefore checked by a later read, whose result is again sampled one cycle after that read is issued. Idle cycles between steps confirm that `bank_en` falls to zero and that `rvalid` stays low.

// File: rtl/cache_bank_pkg.sv
package cache_bank_pkg;
  localparam int WORD_BITS = 64;
  localparam int WORD_BYTES = WORD_BITS / 8;

  // byte-wise merge of new data into an old word
  function automatic logic [WORD_BITS-1:0] merge_bytes(
    input logic [WORD_BITS-1:0] old_w,
    input logic [WORD_BITS-1:0] new_w,
    input logic [WORD_BYTES-1:0] mask);
    logic [WORD_BITS-1:0] r;
    r = old_w;
    for (int k = 0; k < WORD_BYTES; k++)
      if (mask[k]) r[8*k +: 8] = new_w[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 19,
  parameter int BSEL_W = 2,
  parameter int ROW_W  = 7,
  parameter int WSEL_W = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [BSEL_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [WSEL_W-1:0] word
);
  localparam int BYTE_W = 3;
  localparam int WORD_LO = BYTE_W;
  localparam int ROW_LO  = WORD_LO + WSEL_W;
  localparam int BANK_LO = ROW_LO + ROW_W;
  localparam int TAG_LO  = BANK_LO + BSEL_W;

  assign word = addr[WORD_LO +: WSEL_W];
  assign row  = addr[ROW_LO  +: ROW_W];
  assign bank = addr[BANK_LO +: BSEL_W];
  assign tag  = addr[TAG_LO  +: TAG_W];
endmodule

// File: rtl/cache_bank_decode.sv
module cache_bank_decode #(
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = 2
) (
  input  logic                 active,
  input  logic [BSEL_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] en
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_dec
    assign en[i] = active && (bank == BSEL_W'(i));
  end
endmodule

// File: rtl/cache_bank.sv
module cache_bank
  import cache_bank_pkg::*;
#(
  parameter int ROWS       = 128,
  parameter int LINE_WORDS = 2,
  parameter int TAG_W      = 19,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int LINE_BITS = LINE_WORDS * WORD_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  fill,
  input  logic                  wr,
  input  logic [ROW_W-1:0]      row,
  input  logic [WSEL_W-1:0]     word,
  input  logic [TAG_W-1:0]      tag,
  input  logic [WORD_BITS-1:0]  wdata,
  input  logic [WORD_BYTES-1:0] be,
  input  logic [LINE_BITS-1:0]  fill_line,
  output logic                  q_hit,
  output logic [WORD_BITS-1:0]  q_data
);
  logic [WORD_BITS-1:0] mem  [ROWS*LINE_WORDS];
  logic [TAG_W-1:0]     tags [ROWS];
  logic [ROWS-1:0]      vld;

  logic [ROW_W+WSEL_W-1:0] widx;
  logic                    look_hit;
  logic                    do_write;

  assign widx     = {row, word};
  assign look_hit = vld[row] && (tags[row] == tag);
  assign do_write = en && !fill && wr && look_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (en && fill) vld[row] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (en && fill) begin
      for (int w = 0; w < LINE_WORDS; w++)
        mem[{row, WSEL_W'(w)}] <= fill_line[w*WORD_BITS +: WORD_BITS];
      tags[row] <= tag;
    end else if (do_write) begin
      mem[widx] <= merge_bytes(mem[widx], wdata, be);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_hit  <= 1'b0;
      q_data <= '0;
    end else if (en) begin
      q_hit  <= !fill && look_hit;
      q_data <= (!fill && !wr && look_hit) ? mem[widx] : '0;
    end
  end

  // R2: a gated bank keeps its outputs frozen
  a_r2_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(q_data) && $stable(q_hit)));
endmodule

// File: rtl/cache_bank_array.sv
module cache_bank_array
  import cache_bank_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 16,
  parameter int NUM_BANKS   = 4,
  localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES,
  localparam int LINE_BITS  = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_BITS-1:0]  wdata,
  input  logic [WORD_BYTES-1:0] be,
  input  logic                  fill_en,
  input  logic [ADDR_W-1:0]     fill_addr,
  input  logic [LINE_BITS-1:0]  fill_data,
  output logic [NUM_BANKS-1:0]  bank_en,
  output logic                  rvalid,
  output logic                  hit,
  output logic [WORD_BITS-1:0]  rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(CACHE_BYTES / LINE_BYTES);
  localparam int BSEL_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = IDX_W - BSEL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic [ADDR_W-1:0] acc_addr;
  logic              acc_any;
  logic              lookup_go;
  logic [TAG_W-1:0]  a_tag;
  logic [BSEL_W-1:0] a_bank;
  logic [ROW_W-1:0]  a_row;
  logic [WSEL_W-1:0] a_word;

  assign acc_addr  = fill_en ? fill_addr : addr;
  assign acc_any   = fill_en || req;
  assign lookup_go = req && !fill_en;

  cache_addr_split #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .BSEL_W(BSEL_W),
                     .ROW_W(ROW_W), .WSEL_W(WSEL_W)) u_split (
    .addr(acc_addr), .tag(a_tag), .bank(a_bank), .row(a_row), .word(a_word));

  cache_bank_decode #(.NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W)) u_dec (
    .active(acc_any), .bank(a_bank), .en(bank_en));

  logic [WORD_BITS-1:0] bq_data [NUM_BANKS];
  logic                 bq_hit  [NUM_BANKS];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    cache_bank #(.ROWS(ROWS), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(bank_en[i]), .fill(fill_en),
      .wr(we), .row(a_row), .word(a_word), .tag(a_tag),
      .wdata(wdata), .be(be), .fill_line(fill_data),
      .q_hit(bq_hit[i]), .q_data(bq_data[i]));
  end

  logic [BSEL_W-1:0] sel_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      rvalid_q <= lookup_go;
      if (lookup_go) sel_q <= a_bank;
    end
  end

  assign rvalid = rvalid_q;
  assign hit    = rvalid_q && bq_hit[sel_q];
  assign rdata  = rvalid_q ? bq_data[sel_q] : '0;

  // R2: one bank enabled per access
  a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    acc_any |-> ($countones(bank_en) == 1));
  // R3: all banks idle without an access
  a_r3_idle_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_any |-> (bank_en == '0));
  // R4: result follows a request by one cycle
  a_r4_rvalid_next: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_go |=> rvalid);
  // R8: a fill cancels the concurrent request
  a_r8_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !rvalid);
  // R5: misses return zero data
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !hit) |-> (rdata == '0));
endmodule

// File: tb/sim_cache_bank_array.sv
module sim_cache_bank_array;
  localparam int OP_IDLE = 0, OP_FILL = 1, OP_READ = 2, OP_WRITE = 3;

  typedef struct packed {
    logic [1:0]  op;
    logic [18:0] tag;
    logic [1:0]  bank;
    logic [6:0]  row;
    logic        word;
    logic [63:0] data;
    logic [7:0]  be;
    logic        exp_hit;
    logic [63:0] exp_data;
  } step_t;

  localparam int NSTEP = 16;
  localparam step_t STEPS [NSTEP] = '{
    // R9: nothing valid after reset
    '{2'd2, 19'd1, 2'd0, 7'd5, 1'b0, 64'h0, 8'h00, 1'b0, 64'h0},
    // R6: fill a line in bank 0
    '{2'd1, 19'd1, 2'd0, 7'd5, 1'b0, 64'h0123_4567_89AB_CDEF, 8'h00, 1'b0, 64'h0},
    '{2'd2, 19'd1, 2'd0, 7'd5, 1'b0, 64'h0, 8'h00, 1'b1, 64'h0123_4567_89AB_CDEF},
    '{2'd2, 19'd1, 2'd0, 7'd5, 1'b1, 64'h0, 8'h00, 1'b1, 64'hFEDC_BA98_7654_3210},
    // R4: tag mismatch misses
    '{2'd2, 19'd2, 2'd0, 7'd5, 1'b0, 64'h0, 8'h00, 1'b0, 64'h0},
    // R10: same row in another bank is a different line
    '{2'd2, 19'd1, 2'd2, 7'd5, 1'b0, 64'h0, 8'h00, 1'b0, 64'h0},
    '{2'd1, 19'd1, 2'd2, 7'd5, 1'b0, 64'h1111_2222_3333_4444, 8'h00, 1'b0, 64'h0},
    '{2'd2, 19'd1, 2'd2, 7'd5, 1'b0, 64'h0, 8'h00, 1'b1, 64'h1111_2222_3333_4444},
    '{2'd2, 19'd1, 2'd0, 7'd5, 1'b0, 64'h0, 8'h00, 1'b1, 64'h0123_4567_89AB_CDEF},
    // R7: partial write hit, R5: write returns zero
    '{2'd3, 19'd1, 2'd0, 7'd5, 1'b0, 64'hAAAA_AAAA_5555_5555, 8'h0F, 1'b1, 64'h0},
    '{2'd2, 19'd1, 2'd0, 7'd5, 1'b0, 64'h0, 8'h00, 1'b1, 64'h0123_4567_5555_5555},
    // R7: write miss changes nothing
    '{2'd3, 19'd3, 2'd0, 7'd5, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 64'h0},
    '{2'd2, 19'd1, 2'd0, 7'd5, 1'b0, 64'h0, 8'h00, 1'b1, 64'h0123_4567_5555_5555},
    // R1: top row of the top bank
    '{2'd1, 19'd3, 2'd3, 7'd127, 1'b0, 64'hCAFE_F00D_1234_5678, 8'h00, 1'b0, 64'h0},
    '{2'd2, 19'd3, 2'd3, 7'd127, 1'b1, 64'h0, 8'h00, 1'b1, 64'h3501_0FF2_EDCB_A987},
    '{2'd0, 19'd0, 2'd0, 7'd0, 1'b0, 64'h0, 8'h00, 1'b0, 64'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, fill_en = 1'b0;
  logic [31:0] addr = '0, fill_addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0] be = '0;
  logic [127:0] fill_data = '0;
  logic [3:0] bank_en;
  logic rvalid, hit;
  logic [63:0] rdata;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cache_bank_array u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .be(be), .fill_en(fill_en), .fill_addr(fill_addr),
    .fill_data(fill_data), .bank_en(bank_en), .rvalid(rvalid),
    .hit(hit), .rdata(rdata));

  function automatic logic [31:0] mk_addr(logic [18:0] t, logic [1:0] b,
                                          logic [6:0] r, logic w);
    return {t, b, r, w, 3'b101};
  endfunction

  task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle_all();
    req = 0; we = 0; fill_en = 0;
  endtask

  task automatic run_step(step_t s);
    @(negedge clk);
    idle_all();
    case (int'(s.op))
      OP_FILL: begin
        fill_en = 1; fill_addr = mk_addr(s.tag, s.bank, s.row, 1'b0);
        fill_data = {~s.data, s.data};
      end
      OP_READ: begin
        req = 1; addr = mk_addr(s.tag, s.bank, s.row, s.word);
      end
      OP_WRITE: begin
        req = 1; we = 1; addr = mk_addr(s.tag, s.bank, s.row, s.word);
        wdata = s.data; be = s.be;
      end
      default: ;
    endcase
    #1;
    if (s.op == 2'(OP_IDLE)) check("R3 bank_en idle", 64'(bank_en), 64'h0);
    else check("R2 bank_en select", 64'(bank_en), 64'(4'b0001 << s.bank));
    @(negedge clk);
    idle_all();
    #1;
    check("R3 bank_en after step", 64'(bank_en), 64'h0);
    if (s.op == 2'(OP_READ) || s.op == 2'(OP_WRITE)) begin
      check("R4 rvalid", 64'(rvalid), 64'h1);
      check("R4 hit", 64'(hit), 64'(s.exp_hit));
      check("R5 rdata", rdata, s.exp_data);
    end else begin
      check("R4 no rvalid", 64'(rvalid), 64'h0);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset bank_en", 64'(bank_en), 64'h0);
    check("R4 reset rvalid", 64'(rvalid), 64'h0);
    rst_n = 1;
    for (int i = 0; i < NSTEP; i++) run_step(STEPS[i]);

    // R8: fill and request together, fill wins
    @(negedge clk);
    fill_en = 1; fill_addr = mk_addr(19'd5, 2'd1, 7'd0, 1'b0);
    fill_data = {64'h5A5A_0000_FFFF_1234, 64'h7777_8888_9999_AAAA};
    req = 1; we = 1; addr = mk_addr(19'd5, 2'd1, 7'd0, 1'b0);
    wdata = '0; be = 8'hFF;
    #1;
    check("R8 bank_en during fill", 64'(bank_en), 64'h2);
    @(negedge clk);
    idle_all();
    #1;
    check("R8 no rvalid", 64'(rvalid), 64'h0);
    run_step('{2'd2, 19'd5, 2'd1, 7'd0, 1'b0, 64'h0, 8'h00, 1'b1,
               64'h7777_8888_9999_AAAA});
    run_step('{2'd2, 19'd5, 2'd1, 7'd0, 1'b1, 64'h0, 8'h00, 1'b1,
               64'h5A5A_0000_FFFF_1234});
    // R10: bank 3 line untouched by the other fills
    run_step('{2'd2, 19'd3, 2'd3, 7'd127, 1'b0, 64'h0, 8'h00, 1'b1,
               64'hCAFE_F00D_1234_5678});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule